// File: doc/BRIEF.md
# 4x4 Intra Luma Block Predictor

This unit forms a 4x4 block of predicted luma samples from the already reconstructed pixels that border the block: a column of four pixels on the left, a row of eight pixels above (four directly above, four above and to the right) and the single corner pixel above and to the left. A 4-bit mode code picks one of nine predictors: two copy modes, one flat (average) mode and six directional modes. A 4-bit mask tells the unit which neighbour groups exist.

The caller drives the neighbours, the mode and the mask and pulses `start` for one cycle. One cycle later all sixteen samples appear together with a one-cycle `done` pulse. If the chosen mode needs a neighbour group that the mask marks as missing, or if the code is not a valid mode, the result is flagged. The unit fills in missing above-right pixels by itself, and it never lets a pixel from a missing group reach the result. Each directional mode is built as a short line of filtered reference values. The block then reads that line at an index formed from the sample's column and row.

Top module: `intra4_predictor`

## Requirements
- R1: After reset `done`, `err` and every sample are 0. A `start` sampled at a clock edge gives `done` high for exactly the next cycle. Outputs change only on an edge where `start` is high and otherwise hold their value. Back-to-back starts each give a result on consecutive cycles.
- R2: Mode 0 (vertical) sets sample (x,y) to above pixel U[x] for every row.
- R3: Mode 1 (horizontal) sets every sample of row y to left pixel L[y].
- R4: Mode 2 (flat average) gives, in every sample: (sum of U0..U3 + sum of L0..L3 + 4) >> 3 when upper and left are both present; (sum of the present side + 2) >> 2 when only one side is present; 128 when neither is.
- R5: Mode 3 (down-left diagonal) uses line t[i] = F(U[i],U[i+1],U[i+2]) for i = 0..5 and t[6] = (U6 + 3*U7 + 2) >> 2, with sample (x,y) = t[x+y]. F(a,b,c) = (a + 2b + c + 2) >> 2 and A(a,b) = (a + b + 1) >> 1, both truncated to 8 bits.
- R6: Mode 4 (down-right diagonal) uses a 7-entry line of F values centred in turn on L2, L1, L0, corner, U0, U1, U2, with sample (x,y) = t[3+x-y].
- R7: Mode 5 (vertical-right) uses the 10-entry line F@L1, F@L0, F@corner, A(corner,U0), F@U0, A(U0,U1), F@U1, A(U1,U2), F@U2, A(U2,U3), with sample (x,y) = t[3+2x-y].
- R8: Mode 6 (horizontal-down) uses the 10-entry line F@U1, F@U0, F@corner, A(corner,L0), F@L0, A(L0,L1), F@L1, A(L1,L2), F@L2, A(L2,L3), with sample (x,y) = t[3+2y-x].
- R9: Mode 7 (vertical-left) uses line t[2k] = A(U[k],U[k+1]) and t[2k+1] = F(U[k],U[k+1],U[k+2]) for k = 0..4, with sample (x,y) = t[2x+y].
- R10: Mode 8 (horizontal-up) uses line A(L0,L1), F@L1, A(L1,L2), F@L2, A(L2,L3), (L2 + 3*L3 + 2) >> 2, then L3 four times, with sample (x,y) = t[x+2y].
- R11: The mask holds bit 0 for left, bit 1 for upper, bit 2 for corner and bit 3 for above-right. `err` is set and all samples are 0 when the mode code is above 8, or when a mode lacks a group it needs. Modes 0, 3 and 7 need upper. Modes 1 and 8 need left. Modes 4, 5 and 6 need upper, left and corner. Mode 2 is always legal.
- R12: When the above-right bit is clear, U4..U7 are taken as copies of U3. Pixels of any group whose bit is clear have no effect on the samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, samples all inputs |
| mode | input | 4 | Prediction mode code 0..8 |
| avail | input | 4 | Neighbour presence mask |
| left_pix | input | 32 | L0..L3, L[i] at bits 8i+7:8i |
| above_pix | input | 64 | U0..U7, U[i] at bits 8i+7:8i |
| corner_pix | input | 8 | Corner pixel above-left |
| pred | output | 128 | Sample (x,y) at bits 8(4y+x)+7:8(4y+x) |
| done | output | 1 | Result valid, one cycle after start |
| err | output | 1 | Mode/neighbour conflict for the latest result |

## Verification
Two functions can act on the same request: the fill-in of a missing above-right group, and the blocking of pixels from groups marked absent. Down-left and vertical-left requests are sent with the above-right bit clear and random data on U4..U7, while other requests carry random data on missing left or upper groups. The scoreboard computes its expected block only from the pixels that are present, so any leak shows up as a wrong sample. A second pair of functions meets when requests run back to back: a new request is captured on the same edge at which the previous result is shown. Bursts of starts on consecutive cycles are judged by strict first-in first-out order against the queue.

// File: rtl/intra4_pkg.sv
// Shared definitions for the 4x4 intra luma predictor.
// Assumes mode codes 0..8; anything larger is invalid.
package intra4_pkg;
    typedef enum logic [3:0] {
        PM_VERT = 4'd0,
        PM_HORZ = 4'd1,
        PM_FLAT = 4'd2,
        PM_DDL  = 4'd3,
        PM_DDR  = 4'd4,
        PM_VRT  = 4'd5,
        PM_HDN  = 4'd6,
        PM_VLF  = 4'd7,
        PM_HUP  = 4'd8
    } pred_mode_e;

    // Bit positions inside the neighbour presence mask
    localparam int NB_LEFT    = 0;
    localparam int NB_UP      = 1;
    localparam int NB_CORNER  = 2;
    localparam int NB_UPRIGHT = 3;

    localparam int BLK      = 4;
    localparam int LINE_LEN = 10;
    localparam int ABOVE_N  = 2 * BLK;
endpackage

// File: rtl/intra4_legality.sv
// Decides whether a mode code is usable with the given neighbour mask.
// Assumes mask bits per intra4_pkg; above-right presence never matters here.
module intra4_legality
    import intra4_pkg::*;
(
    input  logic [3:0] mode,
    input  logic [2:0] avail,
    output logic       illegal
);
    logic has_l, has_u, has_c;

    assign has_l = avail[NB_LEFT];
    assign has_u = avail[NB_UP];
    assign has_c = avail[NB_CORNER];

    // Map each mode to the neighbour groups it consumes
    always_comb begin
        case (mode)
            PM_VERT, PM_DDL, PM_VLF:  illegal = !has_u;
            PM_HORZ, PM_HUP:          illegal = !has_l;
            PM_FLAT:                  illegal = 1'b0;
            PM_DDR, PM_VRT, PM_HDN:   illegal = !(has_u && has_l && has_c);
            default:                  illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/intra4_nbr_prep.sv
// Cleans neighbour pixels: zeroes groups marked absent and replaces a
// missing above-right group by copies of the last upper pixel.
// Assumes packed pixel order with index 0 in the lowest bits.
module intra4_nbr_prep
    import intra4_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [3:0]               avail,
    input  logic [BLK*PIX_W-1:0]     left_raw,
    input  logic [ABOVE_N*PIX_W-1:0] above_raw,
    input  logic [PIX_W-1:0]         corner_raw,
    output logic [BLK*PIX_W-1:0]     left_cl,
    output logic [ABOVE_N*PIX_W-1:0] above_cl,
    output logic [PIX_W-1:0]         corner_cl
);
    localparam int LW = BLK * PIX_W;

    logic [PIX_W-1:0] last_up;

    // Left column and corner pass only when present
    assign left_cl   = avail[NB_LEFT]   ? left_raw   : '0;
    assign corner_cl = avail[NB_CORNER] ? corner_raw : '0;
    assign above_cl[LW-1:0] = avail[NB_UP] ? above_raw[LW-1:0] : '0;
    assign last_up = above_cl[LW-1 -: PIX_W];

    // Above-right pixels: real data or replicated last upper pixel
    for (genvar i = BLK; i < ABOVE_N; i++) begin : g_ur
        assign above_cl[i*PIX_W +: PIX_W] =
            (avail[NB_UP] && avail[NB_UPRIGHT]) ? above_raw[i*PIX_W +: PIX_W] : last_up;
    end
endmodule

// File: rtl/intra4_line_gen.sv
// Builds the per-mode reference line (up to 10 entries) from cleaned
// neighbours. Copy modes place their source pixels in entries 0..3; the
// flat mode places its average in entry 0. Unused entries are zero.
module intra4_line_gen
    import intra4_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [3:0]                mode,
    input  logic                      has_left,
    input  logic                      has_up,
    input  logic [BLK*PIX_W-1:0]      left_cl,
    input  logic [ABOVE_N*PIX_W-1:0]  above_cl,
    input  logic [PIX_W-1:0]          corner_cl,
    output logic [LINE_LEN*PIX_W-1:0] line_out
);
    localparam logic [PIX_W-1:0] MID = PIX_W'(1) << (PIX_W - 1);

    logic [PIX_W-1:0] l [BLK];
    logic [PIX_W-1:0] u [ABOVE_N];
    logic [PIX_W-1:0] c;
    logic [PIX_W-1:0] t [LINE_LEN];
    logic [PIX_W+1:0] sum_l, sum_u, one_side;
    logic [PIX_W+2:0] both;
    logic [PIX_W-1:0] flat;

    function automatic logic [PIX_W-1:0] tap3(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b,
                                              input logic [PIX_W-1:0] d);
        logic [PIX_W+1:0] s;
        s = {2'b00, a} + {1'b0, b, 1'b0} + {2'b00, d} + (PIX_W+2)'(2);
        return s[PIX_W+1:2];
    endfunction

    function automatic logic [PIX_W-1:0] tap2(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b);
        logic [PIX_W:0] s;
        s = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
        return s[PIX_W:1];
    endfunction

    for (genvar i = 0; i < BLK; i++) begin : g_l
        assign l[i] = left_cl[i*PIX_W +: PIX_W];
    end
    for (genvar i = 0; i < ABOVE_N; i++) begin : g_u
        assign u[i] = above_cl[i*PIX_W +: PIX_W];
    end
    assign c = corner_cl;

    // Flat-mode average over whichever sides are present
    always_comb begin
        sum_l = (PIX_W+2)'(l[0]) + (PIX_W+2)'(l[1]) + (PIX_W+2)'(l[2]) + (PIX_W+2)'(l[3]);
        sum_u = (PIX_W+2)'(u[0]) + (PIX_W+2)'(u[1]) + (PIX_W+2)'(u[2]) + (PIX_W+2)'(u[3]);
        both  = {1'b0, sum_l} + {1'b0, sum_u} + (PIX_W+3)'(4);
        one_side = (has_up ? sum_u : sum_l) + (PIX_W+2)'(2);
        if (has_up && has_left)      flat = both[PIX_W+2:3];
        else if (has_up || has_left) flat = one_side[PIX_W+1:2];
        else                         flat = MID;
    end

    // Reference line per mode
    always_comb begin
        for (int i = 0; i < LINE_LEN; i++) t[i] = '0;
        case (mode)
            PM_VERT: for (int i = 0; i < BLK; i++) t[i] = u[i];
            PM_HORZ: for (int i = 0; i < BLK; i++) t[i] = l[i];
            PM_FLAT: t[0] = flat;
            PM_DDL: begin
                for (int i = 0; i < 6; i++) t[i] = tap3(u[i], u[i+1], u[i+2]);
                t[6] = tap3(u[6], u[7], u[7]);
            end
            PM_DDR: begin
                t[0] = tap3(l[1], l[2], l[3]);
                t[1] = tap3(l[0], l[1], l[2]);
                t[2] = tap3(c, l[0], l[1]);
                t[3] = tap3(l[0], c, u[0]);
                t[4] = tap3(c, u[0], u[1]);
                t[5] = tap3(u[0], u[1], u[2]);
                t[6] = tap3(u[1], u[2], u[3]);
            end
            PM_VRT: begin
                t[0] = tap3(l[0], l[1], l[2]);
                t[1] = tap3(c, l[0], l[1]);
                t[2] = tap3(l[0], c, u[0]);
                t[3] = tap2(c, u[0]);
                t[4] = tap3(c, u[0], u[1]);
                t[5] = tap2(u[0], u[1]);
                t[6] = tap3(u[0], u[1], u[2]);
                t[7] = tap2(u[1], u[2]);
                t[8] = tap3(u[1], u[2], u[3]);
                t[9] = tap2(u[2], u[3]);
            end
            PM_HDN: begin
                t[0] = tap3(u[0], u[1], u[2]);
                t[1] = tap3(c, u[0], u[1]);
                t[2] = tap3(u[0], c, l[0]);
                t[3] = tap2(c, l[0]);
                t[4] = tap3(c, l[0], l[1]);
                t[5] = tap2(l[0], l[1]);
                t[6] = tap3(l[0], l[1], l[2]);
                t[7] = tap2(l[1], l[2]);
                t[8] = tap3(l[1], l[2], l[3]);
                t[9] = tap2(l[2], l[3]);
            end
            PM_VLF: begin
                for (int k = 0; k < 5; k++) begin
                    t[2*k]   = tap2(u[k], u[k+1]);
                    t[2*k+1] = tap3(u[k], u[k+1], u[k+2]);
                end
            end
            PM_HUP: begin
                t[0] = tap2(l[0], l[1]);
                t[1] = tap3(l[0], l[1], l[2]);
                t[2] = tap2(l[1], l[2]);
                t[3] = tap3(l[1], l[2], l[3]);
                t[4] = tap2(l[2], l[3]);
                t[5] = tap3(l[2], l[3], l[3]);
                for (int i = 6; i < LINE_LEN; i++) t[i] = l[3];
            end
            default: ;
        endcase
    end

    for (genvar i = 0; i < LINE_LEN; i++) begin : g_pack
        assign line_out[i*PIX_W +: PIX_W] = t[i];
    end
endmodule

// File: rtl/intra4_sample_map.sv
// Fills the 4x4 block by reading the reference line at an index that is a
// fixed linear function of column x and row y, chosen by mode.
// Assumes the line layout produced by intra4_line_gen.
module intra4_sample_map
    import intra4_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [3:0]                mode,
    input  logic [LINE_LEN*PIX_W-1:0] line_in,
    output logic [BLK*BLK*PIX_W-1:0]  samples
);
    for (genvar gy = 0; gy < BLK; gy++) begin : g_row
        for (genvar gx = 0; gx < BLK; gx++) begin : g_col
            localparam int POS = gy * BLK + gx;
            logic [3:0] idx;

            // Line index for this position under the current mode
            always_comb begin
                case (mode)
                    PM_VERT: idx = 4'(gx);
                    PM_HORZ: idx = 4'(gy);
                    PM_DDL:  idx = 4'(gx + gy);
                    PM_DDR:  idx = 4'(3 + gx - gy);
                    PM_VRT:  idx = 4'(3 + 2*gx - gy);
                    PM_HDN:  idx = 4'(3 + 2*gy - gx);
                    PM_VLF:  idx = 4'(2*gx + gy);
                    PM_HUP:  idx = 4'(gx + 2*gy);
                    default: idx = 4'd0;
                endcase
            end

            assign samples[POS*PIX_W +: PIX_W] = line_in[int'(idx)*PIX_W +: PIX_W];
        end
    end
endmodule

// File: rtl/intra4_predictor.sv
// Top of the 4x4 intra luma predictor. Captures one request per start
// pulse and presents the block, done and err one cycle later.
// Assumes a synchronous active-low reset; outputs hold between requests.
module intra4_predictor
    import intra4_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [3:0]                   mode,
    input  logic [3:0]                   avail,
    input  logic [BLK*PIX_W-1:0]         left_pix,
    input  logic [ABOVE_N*PIX_W-1:0]     above_pix,
    input  logic [PIX_W-1:0]             corner_pix,
    output logic [BLK*BLK*PIX_W-1:0]     pred,
    output logic                         done,
    output logic                         err
);
    logic [BLK*PIX_W-1:0]      left_cl;
    logic [ABOVE_N*PIX_W-1:0]  above_cl;
    logic [PIX_W-1:0]          corner_cl;
    logic [LINE_LEN*PIX_W-1:0] ref_line;
    logic [BLK*BLK*PIX_W-1:0]  block_c;
    logic                      illegal;

    intra4_legality u_legal (
        .mode    (mode),
        .avail   (avail[2:0]),
        .illegal (illegal)
    );

    intra4_nbr_prep #(.PIX_W(PIX_W)) u_prep (
        .avail      (avail),
        .left_raw   (left_pix),
        .above_raw  (above_pix),
        .corner_raw (corner_pix),
        .left_cl    (left_cl),
        .above_cl   (above_cl),
        .corner_cl  (corner_cl)
    );

    intra4_line_gen #(.PIX_W(PIX_W)) u_line (
        .mode      (mode),
        .has_left  (avail[NB_LEFT]),
        .has_up    (avail[NB_UP]),
        .left_cl   (left_cl),
        .above_cl  (above_cl),
        .corner_cl (corner_cl),
        .line_out  (ref_line)
    );

    intra4_sample_map #(.PIX_W(PIX_W)) u_map (
        .mode    (mode),
        .line_in (ref_line),
        .samples (block_c)
    );

    // Capture the result on start; zero block when the request is illegal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                err  <= illegal;
                pred <= illegal ? '0 : block_c;
            end
        end
    end
endmodule

// File: rtl/intra4_predictor_chk.sv
// Property checker for intra4_predictor, attached by bind below.
// Assumes the mask and mode encodings of intra4_pkg.
module intra4_predictor_chk
    import intra4_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic [3:0]                mode,
    input logic [1:0]                side_av,
    input logic [BLK*PIX_W-1:0]      up_row,
    input logic [BLK*BLK*PIX_W-1:0]  pred,
    input logic                      done,
    input logic                      err
);
    localparam int RW = BLK * PIX_W;
    localparam logic [PIX_W-1:0] MID = PIX_W'(1) << (PIX_W - 1);

    assert_done_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    assert_done_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

    assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(pred) && $stable(err)));

    assert_vert_rows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 4'd0 && side_av[1]) |=>
        (pred[RW-1:0] == $past(up_row) && pred[2*RW-1:RW] == $past(up_row) &&
         pred[3*RW-1:2*RW] == $past(up_row) && pred[4*RW-1:3*RW] == $past(up_row)));

    assert_flat_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 4'd2 && side_av == 2'b00) |=> (pred == {(BLK*BLK){MID}}));

    assert_flat_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 4'd2) |=> !err);

    assert_bad_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode > 4'd8) |=> (err && pred == '0));
endmodule

bind intra4_predictor intra4_predictor_chk #(.PIX_W(PIX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .side_av (avail[1:0]),
    .up_row  (above_pix[4*PIX_W-1:0]),
    .pred    (pred),
    .done    (done),
    .err     (err)
);

// File: tb/intra4_predictor_test.sv
// Scoreboard bench: driver pushes expected blocks, monitor pops on done.
module intra4_predictor_test;
    typedef struct {
        logic [127:0] blk;
        logic         e;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [3:0]   mode = '0;
    logic [3:0]   avail = '0;
    logic [31:0]  left_pix = '0;
    logic [63:0]  above_pix = '0;
    logic [7:0]   corner_pix = '0;
    logic [127:0] pred;
    logic         done, err;

    int total = 0;
    int bad = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    intra4_predictor uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .avail(avail),
        .left_pix(left_pix), .above_pix(above_pix), .corner_pix(corner_pix),
        .pred(pred), .done(done), .err(err)
    );

    function automatic int f3(int a, int b, int c);
        return ((a + 2*b + c + 2) >> 2) & 255;
    endfunction
    function automatic int f2(int a, int b);
        return ((a + b + 1) >> 1) & 255;
    endfunction

    // Reference model written from the requirements
    function automatic exp_t model(int md, logic [3:0] av, logic [31:0] lp,
                                   logic [63:0] ap, logic [7:0] cp, string req);
        exp_t r;
        int L[4]; int U[8]; int C; int t[10]; int v;
        bit hl, hu, hc, bad_req;
        hl = av[0]; hu = av[1]; hc = av[2];
        for (int i = 0; i < 4; i++) L[i] = int'(lp[8*i +: 8]);
        for (int i = 0; i < 8; i++) U[i] = int'(ap[8*i +: 8]);
        if (!av[3]) for (int i = 4; i < 8; i++) U[i] = U[3];
        C = int'(cp);
        for (int i = 0; i < 10; i++) t[i] = 0;
        case (md)
            0, 3, 7: bad_req = !hu;
            1, 8:    bad_req = !hl;
            2:       bad_req = 0;
            4, 5, 6: bad_req = !(hu && hl && hc);
            default: bad_req = 1;
        endcase
        r.e = bad_req; r.req = req; r.blk = '0;
        if (bad_req) return r;
        case (md)
            3: begin for (int i = 0; i < 6; i++) t[i] = f3(U[i], U[i+1], U[i+2]);
                     t[6] = ((U[6] + 3*U[7] + 2) >> 2) & 255; end
            4: begin t[0] = f3(L[3], L[2], L[1]); t[1] = f3(L[2], L[1], L[0]);
                     t[2] = f3(L[1], L[0], C); t[3] = f3(L[0], C, U[0]);
                     t[4] = f3(C, U[0], U[1]); t[5] = f3(U[0], U[1], U[2]);
                     t[6] = f3(U[1], U[2], U[3]); end
            5: begin t[0] = f3(L[2], L[1], L[0]); t[1] = f3(L[1], L[0], C);
                     t[2] = f3(L[0], C, U[0]); t[3] = f2(C, U[0]);
                     t[4] = f3(C, U[0], U[1]); t[5] = f2(U[0], U[1]);
                     t[6] = f3(U[0], U[1], U[2]); t[7] = f2(U[1], U[2]);
                     t[8] = f3(U[1], U[2], U[3]); t[9] = f2(U[2], U[3]); end
            6: begin t[0] = f3(U[2], U[1], U[0]); t[1] = f3(U[1], U[0], C);
                     t[2] = f3(U[0], C, L[0]); t[3] = f2(C, L[0]);
                     t[4] = f3(C, L[0], L[1]); t[5] = f2(L[0], L[1]);
                     t[6] = f3(L[0], L[1], L[2]); t[7] = f2(L[1], L[2]);
                     t[8] = f3(L[1], L[2], L[3]); t[9] = f2(L[2], L[3]); end
            7: for (int k = 0; k < 5; k++) begin
                   t[2*k] = f2(U[k], U[k+1]); t[2*k+1] = f3(U[k], U[k+1], U[k+2]);
               end
            8: begin t[0] = f2(L[0], L[1]); t[1] = f3(L[0], L[1], L[2]);
                     t[2] = f2(L[1], L[2]); t[3] = f3(L[1], L[2], L[3]);
                     t[4] = f2(L[2], L[3]); t[5] = ((L[2] + 3*L[3] + 2) >> 2) & 255;
                     for (int i = 6; i < 10; i++) t[i] = L[3]; end
            default: ;
        endcase
        for (int y = 0; y < 4; y++) begin
            for (int x = 0; x < 4; x++) begin
                case (md)
                    0: v = U[x];
                    1: v = L[y];
                    2: begin
                        if (hu && hl) v = (U[0]+U[1]+U[2]+U[3]+L[0]+L[1]+L[2]+L[3]+4) >> 3;
                        else if (hu)  v = (U[0]+U[1]+U[2]+U[3]+2) >> 2;
                        else if (hl)  v = (L[0]+L[1]+L[2]+L[3]+2) >> 2;
                        else          v = 128;
                    end
                    3: v = t[x+y];
                    4: v = t[3+x-y];
                    5: v = t[3+2*x-y];
                    6: v = t[3+2*y-x];
                    7: v = t[2*x+y];
                    default: v = t[x+2*y];
                endcase
                r.blk[8*(4*y+x) +: 8] = 8'(v);
            end
        end
        return r;
    endfunction

    // Driver: present one request for one cycle and queue its expectation
    task automatic send(int md, logic [3:0] av, logic [31:0] lp, logic [63:0] ap,
                        logic [7:0] cp, string req);
        mode = 4'(md); avail = av; left_pix = lp; above_pix = ap; corner_pix = cp;
        start = 1'b1;
        q.push_back(model(md, av, lp, ap, cp, req));
        @(negedge clk);
    endtask

    task automatic idle(int n);
        start = 1'b0;
        mode = 4'hF; avail = '0; left_pix = 32'hDEADBEEF; above_pix = '1; corner_pix = 8'h5A;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare on every done
    always @(negedge clk) begin
        if (rst_n && done) begin
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL R1: done with nothing pending (actual done=1 expected 0)");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (pred !== e.blk || err !== e.e) begin
                    bad++;
                    $display("FAIL %s: actual err=%0b pred=%032h expected err=%0b pred=%032h",
                             e.req, err, pred, e.e, e.blk);
                end
            end
        end
    end

    initial begin
        #400000;
        bad++;
        $display("FAIL R1: watchdog expired (actual hung, expected finish)");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lr; logic [63:0] ar; logic [7:0] cr;
        logic [127:0] held; logic held_err;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (pred !== '0 || done !== 1'b0 || err !== 1'b0) begin
            bad++;
            $display("FAIL R1: reset state actual pred=%032h done=%0b err=%0b expected 0/0/0",
                     pred, done, err);
        end

        lr = 32'h40302010; ar = 64'h8877665544332211; cr = 8'h0F;
        send(0, 4'b0010, 32'hFFFFFFFF, ar, cr, "R2");
        send(1, 4'b0001, lr, 64'hFFFF_FFFF_FFFF_FFFF, cr, "R3");
        idle(2);
        // Flat mode, four presence cases back to back
        send(2, 4'b0011, lr, ar, cr, "R4");
        send(2, 4'b0010, lr, ar, cr, "R4");
        send(2, 4'b0001, lr, ar, cr, "R4");
        send(2, 4'b0000, lr, ar, cr, "R4");
        idle(1);
        // Down-left with and without above-right; garbage in U4..U7 for the latter
        send(3, 4'b1010, lr, ar, cr, "R5");
        send(3, 4'b0010, lr, 64'hA5C3_1E7F_44332211, cr, "R12");
        send(4, 4'b0111, lr, ar, cr, "R6");
        send(5, 4'b0111, lr, ar, cr, "R7");
        send(6, 4'b0111, lr, ar, cr, "R8");
        send(7, 4'b1010, lr, ar, cr, "R9");
        send(7, 4'b0010, lr, 64'h0102_0304_44332211, cr, "R9");
        send(8, 4'b0001, lr, 64'h0, cr, "R10");
        idle(1);
        // Truncation corner: all white
        send(5, 4'b1111, 32'hFFFFFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R7");
        send(8, 4'b0001, 32'hFF00FF00, ar, cr, "R10");
        // Illegal combinations
        send(0, 4'b1101, lr, ar, cr, "R11");
        send(1, 4'b1110, lr, ar, cr, "R11");
        send(4, 4'b0011, lr, ar, cr, "R11");
        send(6, 4'b1011, lr, ar, cr, "R11");
        send(9, 4'b1111, lr, ar, cr, "R11");
        send(15, 4'b1111, lr, ar, cr, "R11");
        send(8, 4'b1110, lr, ar, cr, "R11");
        // Absent groups must not matter
        send(0, 4'b0010, 32'h12345678, ar, 8'h99, "R12");
        send(2, 4'b0001, lr, 64'h1234_5678_9ABC_DEF0, 8'h77, "R12");
        // Random legal requests
        for (int k = 0; k < 40; k++) begin
            lr = $urandom; ar = {$urandom, $urandom}; cr = 8'($urandom);
            send(k % 9, 4'($urandom), lr, ar, cr, "R12");
        end
        idle(2);
        // Hold: no start means outputs stay
        held = pred; held_err = err;
        idle(4);
        total++;
        if (pred !== held || err !== held_err) begin
            bad++;
            $display("FAIL R1: hold actual pred=%032h expected %032h", pred, held);
        end
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R1: results missing actual pending=%0d expected 0", q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule